// File: doc/BRIEF.md
# Setup Register Decoder

This block is the configuration front end of a display controller's I/O space. It watches CPU I/O reads and writes and decodes four configuration locations: a write-only setup control port, a global enable register, an extension enable register and a read-only identification register. From these registers and the RESET, TEST and power-down pins it tracks the controller's operating mode. It also tells the rest of the chip whether the display engine is enabled, whether extension registers may be reached, and at which port pair they live.

The setup control port at 46E8h is always decoded on all 16 address bits. It switches between setup and normal mode and holds the display enable bit. The other three registers exist only in setup mode. In that mode the global enable register answers at every address whose low three bits are 010, so it aliases across the whole I/O space. The RESET pin counts only after it has been held for a minimum number of clocks. A shorter pulse changes nothing except a sticky flag.

The mode state machine has five states:
- RESET, code 0, is entered from any state on a qualified reset. It is held while the pin stays high.
- TEST, code 1, RETIRE, code 2, SETUP, code 3, and NORMAL, code 4, are each chosen on every clock while RESET is low. The choice follows a fixed priority: TEST pin first, then power-down, then the setup bit.
- While RESET is high but not yet qualified, the state holds.

Top module: `cfg_setup_decoder`

## Requirements
- R1: A write to address 46E8h (full 16-bit match) sets the setup bit from data bit 4 and the display enable bit from data bit 3. Setup bit 1 selects SETUP mode on the next clock and 0 selects NORMAL. A read of 46E8h returns rd_valid 0 and rd_data 0.
- R2: In SETUP mode, any address with io_addr[2:0] = 010 reaches the global enable register. Bit 0 is stored and the read value is {7'b0, bit0}.
- R3: In SETUP mode, address 0103h stores data bits 7 and 6 and reads back with all other bits 0. ext_en shows bit 7. ext_port_alt shows bit 6: 0 selects the 3D6h/3D7h pair and 1 selects the 386h/387h pair.
- R4: In SETUP mode, a read of 0104h returns A5h, and writes to 0104h have no effect.
- R5: In NORMAL mode, the global enable, extension enable and ID registers are hidden. Reads of them give rd_valid 0, and writes to them leave them unchanged.
- R6: vga_en is high only when the display enable bit and global enable bit 0 are both 1 and the mode is SETUP or NORMAL.
- R7: Read data is registered: rd_valid and rd_data appear on the clock after io_rd. rd_data is 0 whenever rd_valid is 0.
- R8: RESET held high for 64 consecutive clocks clears every register and the sticky flag on the 64th clock and enters RESET mode (op_mode 0). The block stays in RESET mode while the pin stays high.
- R9: A RESET pulse of 1 to 63 clocks leaves the mode and all registers unchanged. When the pin falls it sets short_rst_seen, which stays set until a qualified reset.
- R10: With RESET low, the next mode is chosen in this order: TEST (op_mode 1) if test_pin is high, else RETIRE (op_mode 2) if pwrdn_pin is high, else SETUP or NORMAL (3 or 4) according to the setup bit.
- R11: cpu_access_ok is high only in SETUP or NORMAL mode with RESET low. While it is low, all reads and writes, including those to 46E8h, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin | input | 1 | RESET pin, active high, qualified by length |
| test_pin | input | 1 | Test mode pin |
| pwrdn_pin | input | 1 | Power-down pin, selects RETIRE |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data is driven |
| vga_en | output | 1 | Display engine enable |
| ext_en | output | 1 | Extension register access enable |
| ext_port_alt | output | 1 | Extension port pair select |
| cpu_access_ok | output | 1 | CPU register and memory access allowed |
| short_rst_seen | output | 1 | Sticky flag: a too-short RESET pulse occurred |
| op_mode | output | 3 | Mode code: 0 reset, 1 test, 2 retire, 3 setup, 4 normal |

## Verification
The checker watches several rules on every cycle:
- the ID value returned in setup mode;
- the absence of valid read data in normal mode;
- zero read data whenever valid is low;
- register stability whenever access is blocked;
- the priority of TEST over the other modes;
- the hold of RESET mode.

Other behaviour can only be shown by the bench's scenarios:
- the exact 63 versus 64 clock boundary of reset qualification;
- the address aliasing of the global register;
- hidden writes issued in normal mode and read back later in setup mode;
- the ignored 46E8h write during retire.

The bench's reference model covers these by comparing all outputs on every clock.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        MODE_RESET  = 3'd0,
        MODE_TEST   = 3'd1,
        MODE_RETIRE = 3'd2,
        MODE_SETUP  = 3'd3,
        MODE_NORMAL = 3'd4
    } op_mode_e;

    localparam logic [ADDR_W-1:0] SETUP_PORT_ADDR = 16'h46E8;
    localparam logic [ADDR_W-1:0] XEN_ADDR        = 16'h0103;
    localparam logic [ADDR_W-1:0] ID_ADDR         = 16'h0104;
    localparam logic [2:0]        GLB_ALIAS_LOW   = 3'b010;
    localparam logic [DATA_W-1:0] CHIP_ID         = 8'hA5;

    localparam int SP_SETUP_BIT = 4;
    localparam int SP_VGA_BIT   = 3;
    localparam int GLB_EN_BIT   = 0;
    localparam int XEN_ACC_BIT  = 7;
    localparam int XEN_ALT_BIT  = 6;
endpackage

// File: rtl/cfgdec_rst_qual.sv
module cfgdec_rst_qual #(
    parameter int RST_MIN_CYC = 64
) (
    input  logic clk,
    input  logic rst_pin,
    output logic rst_hit,
    output logic short_seen
);
    localparam int CW = $clog2(RST_MIN_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_MIN_CYC - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(RST_MIN_CYC);

    logic [CW-1:0] high_cnt;

    // Qualified on the edge that completes the required run of high clocks
    assign rst_hit = rst_pin && (high_cnt >= CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst_pin) begin
            if (high_cnt != CNT_SAT)
                high_cnt <= high_cnt + 1'b1;
        end else begin
            high_cnt <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_hit)
            short_seen <= 1'b0;
        else if (!rst_pin && (high_cnt != '0) && (high_cnt < CNT_SAT))
            short_seen <= 1'b1;
    end
endmodule

// File: rtl/cfgdec_regs.sv
module cfgdec_regs
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_hit,
    input  logic              acc_ok,
    input  logic              in_setup,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              setup_nxt,
    output logic              port_vga,
    output logic              glb_en,
    output logic              xen_acc,
    output logic              xen_alt
);
    logic setup_q;
    logic sel_port, sel_glb, sel_xen, sel_id;
    logic wr_go, rd_go;
    logic rd_hit;
    logic [DATA_W-1:0] rd_word;

    assign sel_port = (io_addr == SETUP_PORT_ADDR);
    // Global register aliases on the low three address bits in setup mode
    assign sel_glb  = in_setup && !sel_port && (io_addr[2:0] == GLB_ALIAS_LOW);
    assign sel_xen  = in_setup && (io_addr == XEN_ADDR);
    assign sel_id   = in_setup && (io_addr == ID_ADDR);

    assign wr_go = acc_ok && io_wr;
    assign rd_go = acc_ok && io_rd;

    always_comb begin
        rd_hit  = 1'b0;
        rd_word = '0;
        if (sel_glb) begin
            rd_hit              = 1'b1;
            rd_word[GLB_EN_BIT] = glb_en;
        end else if (sel_xen) begin
            rd_hit               = 1'b1;
            rd_word[XEN_ACC_BIT] = xen_acc;
            rd_word[XEN_ALT_BIT] = xen_alt;
        end else if (sel_id) begin
            rd_hit  = 1'b1;
            rd_word = CHIP_ID;
        end
    end

    always_comb begin
        if (rst_hit)
            setup_nxt = 1'b0;
        else if (wr_go && sel_port)
            setup_nxt = io_wdata[SP_SETUP_BIT];
        else
            setup_nxt = setup_q;
    end

    always_ff @(posedge clk) begin
        if (rst_hit) begin
            setup_q  <= 1'b0;
            port_vga <= 1'b0;
            glb_en   <= 1'b0;
            xen_acc  <= 1'b0;
            xen_alt  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            setup_q <= setup_nxt;
            if (wr_go && sel_port)
                port_vga <= io_wdata[SP_VGA_BIT];
            if (wr_go && sel_glb)
                glb_en <= io_wdata[GLB_EN_BIT];
            if (wr_go && sel_xen) begin
                xen_acc <= io_wdata[XEN_ACC_BIT];
                xen_alt <= io_wdata[XEN_ALT_BIT];
            end
            rd_valid <= rd_go && rd_hit;
            rd_data  <= (rd_go && rd_hit) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/cfgdec_mode_fsm.sv
module cfgdec_mode_fsm
    import cfgdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_pin,
    input  logic       rst_hit,
    input  logic       test_pin,
    input  logic       pwrdn_pin,
    input  logic       setup_nxt,
    output logic [2:0] op_mode,
    output logic       acc_ok,
    output logic       in_setup,
    output logic       live
);
    op_mode_e state_q, state_d, pin_pick;

    always_comb begin
        if (test_pin)
            pin_pick = MODE_TEST;
        else if (pwrdn_pin)
            pin_pick = MODE_RETIRE;
        else if (setup_nxt)
            pin_pick = MODE_SETUP;
        else
            pin_pick = MODE_NORMAL;
    end

    always_comb begin
        state_d = state_q;
        if (rst_hit)
            state_d = MODE_RESET;
        else if (!rst_pin)
            state_d = pin_pick;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        live     = 1'b0;
        in_setup = 1'b0;
        unique case (state_q)
            MODE_SETUP: begin
                live     = 1'b1;
                in_setup = 1'b1;
            end
            MODE_NORMAL: live = 1'b1;
            MODE_RESET, MODE_TEST, MODE_RETIRE: live = 1'b0;
            default: live = 1'b0;
        endcase
        acc_ok = live && !rst_pin;
    end

    assign op_mode = state_q;
endmodule

// File: rtl/cfg_setup_decoder.sv
module cfg_setup_decoder
    import cfgdec_pkg::*;
#(
    parameter int RST_MIN_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_pin,
    input  logic              test_pin,
    input  logic              pwrdn_pin,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              vga_en,
    output logic              ext_en,
    output logic              ext_port_alt,
    output logic              cpu_access_ok,
    output logic              short_rst_seen,
    output logic [2:0]        op_mode
);
    logic rst_hit, setup_nxt, port_vga, glb_en;
    logic acc_ok, in_setup, live;

    cfgdec_rst_qual #(.RST_MIN_CYC(RST_MIN_CYC)) u_rq (
        .clk        (clk),
        .rst_pin    (rst_pin),
        .rst_hit    (rst_hit),
        .short_seen (short_rst_seen)
    );

    cfgdec_regs u_regs (
        .clk       (clk),
        .rst_hit   (rst_hit),
        .acc_ok    (acc_ok),
        .in_setup  (in_setup),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .setup_nxt (setup_nxt),
        .port_vga  (port_vga),
        .glb_en    (glb_en),
        .xen_acc   (ext_en),
        .xen_alt   (ext_port_alt)
    );

    cfgdec_mode_fsm u_fsm (
        .clk       (clk),
        .rst_pin   (rst_pin),
        .rst_hit   (rst_hit),
        .test_pin  (test_pin),
        .pwrdn_pin (pwrdn_pin),
        .setup_nxt (setup_nxt),
        .op_mode   (op_mode),
        .acc_ok    (acc_ok),
        .in_setup  (in_setup),
        .live      (live)
    );

    assign cpu_access_ok = acc_ok;
    assign vga_en        = port_vga && glb_en && live;
endmodule

// File: rtl/cfgdec_chk.sv
module cfgdec_chk (
    input logic        clk,
    input logic        rst_pin,
    input logic        test_pin,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input logic        vga_en,
    input logic        ext_en,
    input logic        ext_port_alt,
    input logic        cpu_access_ok,
    input logic        short_rst_seen,
    input logic [2:0]  op_mode
);
    assert_id_value_R4: assert property (@(posedge clk) disable iff (rst_pin)
        (io_rd && io_addr == 16'h0104 && cpu_access_ok && op_mode == 3'd3)
        |=> (rd_valid && rd_data == 8'hA5));

    assert_hidden_R5: assert property (@(posedge clk) disable iff (rst_pin)
        (io_rd && op_mode == 3'd4) |=> !rd_valid);

    assert_vga_live_R6: assert property (@(posedge clk) disable iff (rst_pin)
        vga_en |-> (op_mode == 3'd3 || op_mode == 3'd4));

    assert_rd_zero_R7: assert property (@(posedge clk) disable iff (rst_pin)
        !rd_valid |-> (rd_data == 8'h00));

    assert_rd_cause_R7: assert property (@(posedge clk) disable iff (rst_pin)
        rd_valid |-> $past(io_rd && cpu_access_ok));

    assert_reset_hold_R8: assert property (@(posedge clk)
        (op_mode == 3'd0 && rst_pin) |=> (op_mode == 3'd0));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst_pin)
        $fell(short_rst_seen) |-> $past(rst_pin));

    assert_test_prio_R10: assert property (@(posedge clk) disable iff (rst_pin)
        test_pin |=> (op_mode == 3'd1));

    assert_locked_R11: assert property (@(posedge clk) disable iff (rst_pin)
        !cpu_access_ok |=> ($stable(ext_en) && $stable(ext_port_alt)));

    assert_access_mode_R11: assert property (@(posedge clk) disable iff (rst_pin)
        cpu_access_ok |-> (op_mode == 3'd3 || op_mode == 3'd4));
endmodule

bind cfg_setup_decoder cfgdec_chk u_chk (
    .clk            (clk),
    .rst_pin        (rst_pin),
    .test_pin       (test_pin),
    .io_addr        (io_addr),
    .io_rd          (io_rd),
    .rd_data        (rd_data),
    .rd_valid       (rd_valid),
    .vga_en         (vga_en),
    .ext_en         (ext_en),
    .ext_port_alt   (ext_port_alt),
    .cpu_access_ok  (cpu_access_ok),
    .short_rst_seen (short_rst_seen),
    .op_mode        (op_mode)
);

// File: tb/sim_cfg_setup_decoder.sv
`timescale 1ns/1ps
module sim_cfg_setup_decoder;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_pin = 1'b1, test_pin = 1'b0, pwrdn_pin = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid, vga_en, ext_en, ext_port_alt, cpu_access_ok, short_rst_seen;
    logic [2:0]  op_mode;

    cfg_setup_decoder u0 (
        .clk(clk), .rst_pin(rst_pin), .test_pin(test_pin), .pwrdn_pin(pwrdn_pin),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
        .rd_data(rd_data), .rd_valid(rd_valid), .vga_en(vga_en), .ext_en(ext_en),
        .ext_port_alt(ext_port_alt), .cpu_access_ok(cpu_access_ok),
        .short_rst_seen(short_rst_seen), .op_mode(op_mode)
    );

    int checks = 0, errors = 0;
    // behavioural reference state
    int m_cnt = 0, m_mode = 0, e_rdd = 0;
    bit m_known = 0, m_setup, m_vga, m_glb, m_x7, m_x6, m_short, e_rdv;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        bit ok, hit, live;
        ok  = (m_mode == 3 || m_mode == 4) && !rst_pin;
        hit = rst_pin && (m_cnt >= 63);
        e_rdv = 0; e_rdd = 0;
        if (ok && io_rd && io_addr != 16'h46E8 && m_mode == 3) begin
            if (io_addr[2:0] == 3'b010) begin e_rdv = 1; e_rdd = int'(m_glb); end
            else if (io_addr == 16'h0103) begin e_rdv = 1; e_rdd = m_x7 * 128 + m_x6 * 64; end
            else if (io_addr == 16'h0104) begin e_rdv = 1; e_rdd = 'hA5; end
        end
        if (ok && io_wr) begin
            if (io_addr == 16'h46E8) begin m_setup = io_wdata[4]; m_vga = io_wdata[3]; end
            else if (m_mode == 3 && io_addr[2:0] == 3'b010) m_glb = io_wdata[0];
            else if (m_mode == 3 && io_addr == 16'h0103) begin m_x7 = io_wdata[7]; m_x6 = io_wdata[6]; end
        end
        if (!rst_pin && m_cnt > 0 && m_cnt < 64) m_short = 1;
        if (rst_pin) m_cnt = (m_cnt < 64) ? m_cnt + 1 : 64; else m_cnt = 0;
        if (hit) begin
            m_setup = 0; m_vga = 0; m_glb = 0; m_x7 = 0; m_x6 = 0; m_short = 0;
            m_mode = 0; m_known = 1; e_rdv = 0; e_rdd = 0;
        end else if (!rst_pin) begin
            m_mode = test_pin ? 1 : pwrdn_pin ? 2 : m_setup ? 4 - 1 : 4;
        end
        @(posedge clk); #1;
        if (m_known) begin
            live = (m_mode == 3 || m_mode == 4);
            chk({tag, " rd_valid"}, int'(rd_valid), int'(e_rdv));
            chk({tag, " rd_data"}, int'(rd_data), e_rdd);
            chk({tag, " vga_en"}, int'(vga_en), int'(m_vga && m_glb && live));
            chk({tag, " ext_en"}, int'(ext_en), int'(m_x7));
            chk({tag, " ext_port_alt"}, int'(ext_port_alt), int'(m_x6));
            chk({tag, " cpu_access_ok"}, int'(cpu_access_ok), int'(live && !rst_pin));
            chk({tag, " op_mode"}, int'(op_mode), m_mode);
            chk({tag, " short_rst_seen"}, int'(short_rst_seen), int'(m_short));
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step(tag);
        io_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, string tag);
        io_addr = a; io_rd = 1'b1;
        step(tag);
        io_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(70, "R8 power-up reset");
        chk("R8 reset mode", int'(op_mode), 0);
        chk("R8 reset vga_en", int'(vga_en), 0);
        rst_pin = 1'b0;
        idle(1, "R10 release");
        chk("R10 normal after reset", int'(op_mode), 4);

        rd(16'h0102, "R5 hidden read");
        chk("R5 hidden read valid", int'(rd_valid), 0);
        wr(16'h0102, 8'h01, "R5 hidden write");
        wr(16'h46E8, 8'h10, "R1 enter setup");
        chk("R1 setup mode", int'(op_mode), 3);
        rd(16'h0102, "R5 hidden write had no effect");
        chk("R5 glb unchanged", int'(rd_data), 0);

        wr(16'hFA02, 8'hFF, "R2 alias write");
        chk("R6 vga_en needs port bit", int'(vga_en), 0);
        wr(16'h46E8, 8'h18, "R1 vga bit");
        chk("R6 vga_en on", int'(vga_en), 1);
        rd(16'h46E8, "R1 write-only read");
        chk("R1 port read invalid", int'(rd_valid), 0);
        rd(16'h0102, "R2 read");
        chk("R2 glb read", int'(rd_data), 1);
        rd(16'h3C02, "R2 alias read");
        chk("R2 alias read", int'(rd_data), 1);
        idle(1, "R7 idle");
        chk("R7 valid drops", int'(rd_valid), 0);

        wr(16'h0103, 8'hFF, "R3 write");
        rd(16'h0103, "R3 read");
        chk("R3 reserved bits zero", int'(rd_data), 'hC0);
        chk("R3 ext_en", int'(ext_en), 1);
        wr(16'h0103, 8'h40, "R3 alt only");
        chk("R3 ext_en off", int'(ext_en), 0);
        chk("R3 alt pair", int'(ext_port_alt), 1);

        rd(16'h0104, "R4 id");
        chk("R4 id value", int'(rd_data), 'hA5);
        wr(16'h0104, 8'h00, "R4 id write");
        rd(16'h0104, "R4 id after write");
        chk("R4 id unchanged", int'(rd_data), 'hA5);

        wr(16'h46E8, 8'h08, "R1 back to normal");
        chk("R1 normal mode", int'(op_mode), 4);
        chk("R6 vga_en in normal", int'(vga_en), 1);
        rd(16'h0104, "R5 id hidden");
        chk("R5 id hidden", int'(rd_valid), 0);
        wr(16'h0103, 8'h80, "R5 ext write hidden");
        chk("R5 ext unchanged", int'(ext_en), 0);

        pwrdn_pin = 1'b1;
        idle(1, "R10 retire");
        chk("R10 retire mode", int'(op_mode), 2);
        chk("R11 no access in retire", int'(cpu_access_ok), 0);
        chk("R6 vga_en off in retire", int'(vga_en), 0);
        wr(16'h46E8, 8'h10, "R11 ignored port write");
        pwrdn_pin = 1'b0;
        idle(1, "R11 leave retire");
        chk("R11 port write ignored", int'(op_mode), 4);
        test_pin = 1'b1; pwrdn_pin = 1'b1;
        idle(2, "R10 test prio");
        chk("R10 test over retire", int'(op_mode), 1);
        test_pin = 1'b0; pwrdn_pin = 1'b0;
        idle(1, "R10 leave test");

        rst_pin = 1'b1;
        idle(20, "R9 short pulse");
        chk("R11 access blocked by pin", int'(cpu_access_ok), 0);
        rst_pin = 1'b0;
        idle(1, "R9 short end");
        chk("R9 sticky set", int'(short_rst_seen), 1);
        chk("R9 mode kept", int'(op_mode), 4);
        chk("R9 alt kept", int'(ext_port_alt), 1);
        rst_pin = 1'b1;
        idle(63, "R9 63 clocks");
        rst_pin = 1'b0;
        idle(1, "R9 63 end");
        chk("R9 63 ignored", int'(vga_en), 1);
        rst_pin = 1'b1;
        idle(64, "R8 64 clocks");
        chk("R8 qualified", int'(op_mode), 0);
        chk("R8 sticky cleared", int'(short_rst_seen), 0);
        chk("R8 alt cleared", int'(ext_port_alt), 0);
        idle(3, "R8 hold");
        chk("R8 hold reset", int'(op_mode), 0);
        rst_pin = 1'b0;
        idle(2, "R10 after second reset");
        chk("R10 normal again", int'(op_mode), 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule